// File: doc/BRIEF.md
# Indirect Configuration Access Engine

This block serves configuration-space requests through a pair of registers on a simple downstream register bus: an address register that selects the target, and a data register that moves the 32-bit word. Each request names a bus, a device, a function, a 12-bit register offset and an access size of 1, 2 or 4 bytes. A request is either a read or a write, and a write carries its data. The engine handles one request at a time. It always writes the address word first. For a read it then fetches the data word and returns the addressed byte or halfword. A 4-byte write goes straight to the data register. A narrower write reads the data word, replaces one lane and writes the word back.

The state machine has five states. ST_IDLE accepts a request (transition *accept*). A request with an unsupported size goes directly to ST_RESP (transition *reject*). ST_ADDR_WR writes the address word. On its handshake the machine moves to ST_DATA_RD when it must read (*need_read*: any read, or a narrow write) and to ST_DATA_WR otherwise (*full_write*). ST_DATA_RD reads the data word. On its handshake it moves to ST_DATA_WR for a narrow write (*merge*) and to ST_RESP for a read (*read_done*). ST_DATA_WR writes the final word and then moves to ST_RESP (*write_done*). ST_RESP raises the done strobe for one cycle and returns to ST_IDLE (*finish*).

Top module: `cfg_indirect_engine`

## Requirements
- R1: The address word has bit 31 set. It holds the bus number in bits 23:16, the device in bits 15:11 and the function in bits 10:8. Offset bits 7:2 appear unchanged in bits 7:2, and offset bits 11:8 appear in bits 27:24. Bits 30:28 and 1:0 are zero.
- R2: Every accepted request with a valid size begins with a write of the address word to the address register. This write comes before any access to the data register.
- R3: A 4-byte read performs exactly one data-register read and returns the full 32-bit word.
- R4: A 1-byte read returns the fetched word shifted right by 8 × offset[1:0] and masked to 8 bits.
- R5: A 2-byte read returns the fetched word shifted right by 8 × offset[1:0] and masked to 16 bits. With offset[1:0] = 3, only the top byte of the word is returned.
- R6: A 1-byte or 2-byte write reads the data word, clears the lane at shift 8 × offset[1:0], inserts the low bits of the write data there and writes the word back. Bits outside the lane are preserved. A lane that would reach past bit 31 is truncated.
- R7: A 4-byte write performs no data-register read. It writes the write data unchanged with one data-register write.
- R8: A request whose size is not 1, 2 or 4 completes with status 1 (bad register) and read data 0. It causes no bus transaction at all.
- R9: The done strobe is a single-cycle pulse. A valid request reports status 0 (success). A write returns read data 0.
- R10: The busy output is high from the cycle after acceptance through the done cycle, and the request-ready output is its inverse. Request fields presented while busy are ignored.
- R11: While a bus request is waiting for ready, valid stays high and the address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Sequence in progress |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_status | output | 1 | 0 = success, 1 = bad register size |
| rsp_rdata | output | 32 | Extracted read data |
| bus_valid | output | 1 | Downstream transaction valid |
| bus_ready | input | 1 | Downstream transaction accepted |
| bus_write | output | 1 | Downstream direction, 1 = write |
| bus_addr | output | ADDR_W | Downstream register offset |
| bus_wdata | output | 32 | Downstream write data |
| bus_rdata | input | 32 | Downstream read data, valid with ready |

## Verification
The bench goes after the lane arithmetic at every byte position, including a halfword at offset 3. A design that masked before shifting, or that wrapped the lane around, would return or corrupt the wrong bytes there. Narrow writes are checked against a preloaded data word. A merge that skipped the read would destroy the neighbouring bytes, and a 4-byte write that still read first would show up in the transaction counts. Rejected sizes are checked for zero bus activity. Requests presented while busy are checked for no effect, which catches an engine that re-latches its inputs mid-sequence. Random bus stalls exercise the hold rules.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_WR,
        ST_DATA_RD,
        ST_DATA_WR,
        ST_RESP
    } cfg_state_e;

    localparam logic STAT_OK  = 1'b0;
    localparam logic STAT_BAD = 1'b1;
endpackage

// File: rtl/cfg_addr_pack.sv
module cfg_addr_pack
    import cfg_pkg::*;
(
    input  logic [7:0]        bus_num,
    input  logic [4:0]        dev_num,
    input  logic [2:0]        fn_num,
    input  logic [OFF_W-1:2]  reg_off,
    output logic [WORD_W-1:0] addr_word
);
    always_comb begin
        addr_word        = '0;
        addr_word[31]    = 1'b1;
        addr_word[27:24] = reg_off[11:8];
        addr_word[23:16] = bus_num;
        addr_word[15:11] = dev_num;
        addr_word[10:8]  = fn_num;
        addr_word[7:2]   = reg_off[7:2];
    end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] new_data,
    input  logic [1:0]        byte_sel,
    input  logic [2:0]        size,
    output logic [WORD_W-1:0] extracted,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] size_mask;
    logic [WORD_W-1:0] lane_mask;
    logic [4:0]        shamt;

    always_comb begin
        unique case (size)
            3'd1:    size_mask = 32'h0000_00FF;
            3'd2:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
        shamt     = (size == 3'd4) ? 5'd0 : {byte_sel, 3'b000};
        lane_mask = size_mask << shamt;
        extracted = (word_in >> shamt) & size_mask;
        merged    = (word_in & ~lane_mask) | ((new_data & size_mask) << shamt);
    end
endmodule

// File: rtl/cfg_indirect_engine.sv
module cfg_indirect_engine
    import cfg_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] ADDR_REG_OFS = 'h080,
    parameter logic [ADDR_W-1:0] DATA_REG_OFS = 'h084
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_bus,
    input  logic [4:0]        req_dev,
    input  logic [2:0]        req_fn,
    input  logic [11:0]       req_off,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic              rsp_status,
    output logic [31:0]       rsp_rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    cfg_state_e state_q, state_d;

    logic [7:0]        bus_q;
    logic [4:0]        dev_q;
    logic [2:0]        fn_q;
    logic [OFF_W-1:0]  off_q;
    logic [2:0]        size_q;
    logic              wr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rd_word_q;
    logic              status_q;

    logic              accept;
    logic              size_ok;
    logic [WORD_W-1:0] addr_word;
    logic [WORD_W-1:0] lane_extract;
    logic [WORD_W-1:0] lane_merge;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

    cfg_addr_pack u_pack (
        .bus_num   (bus_q),
        .dev_num   (dev_q),
        .fn_num    (fn_q),
        .reg_off   (off_q[OFF_W-1:2]),
        .addr_word (addr_word)
    );

    cfg_lane_unit u_lane (
        .word_in   (rd_word_q),
        .new_data  (wdata_q),
        .byte_sel  (off_q[1:0]),
        .size      (size_q),
        .extracted (lane_extract),
        .merged    (lane_merge)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = size_ok ? ST_ADDR_WR : ST_RESP;
            ST_ADDR_WR: if (bus_ready)
                            state_d = (!wr_q || size_q != 3'd4) ? ST_DATA_RD : ST_DATA_WR;
            ST_DATA_RD: if (bus_ready) state_d = wr_q ? ST_DATA_WR : ST_RESP;
            ST_DATA_WR: if (bus_ready) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q     <= '0;
            dev_q     <= '0;
            fn_q      <= '0;
            off_q     <= '0;
            size_q    <= '0;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            rd_word_q <= '0;
            status_q  <= STAT_OK;
        end else if (accept) begin
            bus_q     <= req_bus;
            dev_q     <= req_dev;
            fn_q      <= req_fn;
            off_q     <= req_off;
            size_q    <= req_size;
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            rd_word_q <= '0;
            status_q  <= size_ok ? STAT_OK : STAT_BAD;
        end else if (state_q == ST_DATA_RD && bus_ready) begin
            rd_word_q <= bus_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        rsp_done   = (state_q == ST_RESP);
        rsp_status = status_q;
        rsp_rdata  = (wr_q || status_q == STAT_BAD) ? '0 : lane_extract;
        bus_valid  = 1'b0;
        bus_write  = 1'b0;
        bus_addr   = DATA_REG_OFS;
        bus_wdata  = '0;
        unique case (state_q)
            ST_ADDR_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = ADDR_REG_OFS;
                bus_wdata = addr_word;
            end
            ST_DATA_RD: bus_valid = 1'b1;
            ST_DATA_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = lane_merge;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_indirect_engine_chk.sv
module cfg_indirect_engine_chk #(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] ADDR_REG_OFS = 'h080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              rsp_done,
    input logic              rsp_status,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata
);
    p_addr_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_REG_OFS)
            |-> (bus_wdata[31] && bus_wdata[30:28] == 3'b000 && bus_wdata[1:0] == 2'b00));

    p_addr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rsp_done || (bus_valid && bus_write && bus_addr == ADDR_REG_OFS)));

    p_bad_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status) |-> $past(!bus_valid));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (busy && !req_ready));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready)
            |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));
endmodule

bind cfg_indirect_engine cfg_indirect_engine_chk #(
    .ADDR_W       (ADDR_W),
    .ADDR_REG_OFS (ADDR_REG_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .busy       (busy),
    .rsp_done   (rsp_done),
    .rsp_status (rsp_status),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
);

// File: tb/cfg_indirect_engine_tb.sv
module cfg_indirect_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam logic [ADDR_W-1:0] A_OFS = 'h080;
    localparam logic [ADDR_W-1:0] D_OFS = 'h084;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic busy, rsp_done, rsp_status;
    logic [31:0] rsp_rdata;
    logic bus_valid, bus_write;
    logic bus_ready = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // bench register model and log
    logic [31:0] areg = '0;
    logic [31:0] dreg = '0;
    int n_aw = 0, n_dr = 0, n_dw = 0, n_bad_addr = 0;
    int first_kind = 0; // 1 = address write, 2 = other, 0 = none
    int stall = 0;
    logic [31:0] got_rdata;
    logic        got_status;

    cfg_indirect_engine #(
        .ADDR_W(ADDR_W), .ADDR_REG_OFS(A_OFS), .DATA_REG_OFS(D_OFS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    // downstream register slave, acting at falling edges
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!bus_valid) begin
                bus_ready = 1'b0;
                cnt = stall;
            end else if (cnt > 0) begin
                bus_ready = 1'b0;
                cnt--;
            end else begin
                bus_ready = 1'b1;
                cnt = stall;
                if (first_kind == 0)
                    first_kind = (bus_write && bus_addr == A_OFS) ? 1 : 2;
                if (bus_write && bus_addr == A_OFS) begin
                    areg = bus_wdata; n_aw++;
                end else if (bus_write && bus_addr == D_OFS) begin
                    dreg = bus_wdata; n_dw++;
                end else if (!bus_write && bus_addr == D_OFS) begin
                    bus_rdata = dreg; n_dr++;
                end else begin
                    n_bad_addr++;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [4:0] d,
                                             input logic [2:0] f, input logic [11:0] o);
        return 32'h8000_0000 | ({28'd0, o[11:8]} << 24) | ({24'd0, b} << 16)
             | ({27'd0, d} << 11) | ({29'd0, f} << 8) | {24'd0, o[7:2], 2'b00};
    endfunction

    task automatic do_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                          input logic [11:0] o, input logic [2:0] sz, input logic wr,
                          input logic [31:0] wd, input bit junk);
        int guard;
        @(negedge clk);
        n_aw = 0; n_dr = 0; n_dw = 0; n_bad_addr = 0; first_kind = 0;
        req_bus = b; req_dev = d; req_fn = f; req_off = o;
        req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            req_bus = ~b; req_dev = ~d; req_off = ~o; req_size = 3'd4;
            req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
        end else begin
            req_valid = 1'b0;
        end
        guard = 0;
        while (!rsp_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        got_rdata = rsp_rdata;
        got_status = rsp_status;
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 done pulse", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic t_reset();
        check("R10 reset ready", {31'd0, req_ready}, 32'd1);
        check("R10 reset busy", {31'd0, busy}, 32'd0);
        check("R11 reset bus idle", {31'd0, bus_valid}, 32'd0);
        check("R9 reset done", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic t_addr_layout();
        stall = 0;
        dreg = 32'h1234_5678;
        do_req(8'hA5, 5'h13, 3'h6, 12'hD7C, 3'd4, 1'b0, '0, 1'b0);
        check("R1 address word", areg, exp_addr(8'hA5, 5'h13, 3'h6, 12'hD7C));
        check("R1 address literal", areg, 32'h8DA5_9E7C);
        check("R2 address first", first_kind, 1);
        check("R3 full read data", got_rdata, 32'h1234_5678);
        check("R3 one data read", n_dr, 1);
        check("R9 status ok", {31'd0, got_status}, 32'd0);
    endtask

    task automatic t_read_byte();
        stall = 1;
        dreg = 32'hC3B2_A190;
        for (int k = 0; k < 4; k++) begin
            do_req(8'h01, 5'h00, 3'h0, 12'h010 + 12'(k), 3'd1, 1'b0, '0, 1'b0);
            check("R4 byte lane", got_rdata, (32'hC3B2_A190 >> (8 * k)) & 32'hFF);
        end
    endtask

    task automatic t_read_half();
        stall = 2;
        dreg = 32'h8877_6655;
        for (int k = 0; k < 4; k++) begin
            do_req(8'h02, 5'h1F, 3'h7, 12'hFF0 + 12'(k), 3'd2, 1'b0, '0, 1'b0);
            check("R5 half lane", got_rdata, (32'h8877_6655 >> (8 * k)) & 32'hFFFF);
        end
        check("R5 half at lane3 top byte only", got_rdata, 32'h0000_0088);
    endtask

    task automatic t_write_narrow();
        logic [63:0] lm;
        stall = 1;
        for (int k = 0; k < 4; k++) begin
            dreg = 32'h1122_3344;
            do_req(8'h03, 5'h04, 3'h1, 12'h100 + 12'(k), 3'd1, 1'b1, 32'hFFFF_FFAB, 1'b0);
            lm = 64'hFF << (8 * k);
            check("R6 byte merge", dreg,
                  32'((64'h1122_3344 & ~lm) | ((64'hAB << (8 * k)) & lm)));
            check("R6 read before write", n_dr * 10 + n_dw, 11);
            check("R9 write rdata zero", got_rdata, 32'd0);
        end
        dreg = 32'h1122_3344;
        do_req(8'h03, 5'h04, 3'h1, 12'h102, 3'd2, 1'b1, 32'h0000_BEEF, 1'b0);
        check("R6 half merge", dreg, 32'hBEEF_3344);
        dreg = 32'h1122_3344;
        do_req(8'h03, 5'h04, 3'h1, 12'h103, 3'd2, 1'b1, 32'h0000_BEEF, 1'b0);
        check("R6 half truncated at lane3", dreg, 32'hEF22_3344);
    endtask

    task automatic t_write_word();
        stall = 3;
        dreg = 32'h5555_5555;
        do_req(8'h7E, 5'h02, 3'h3, 12'h204, 3'd4, 1'b1, 32'hCAFE_F00D, 1'b0);
        check("R7 word written", dreg, 32'hCAFE_F00D);
        check("R7 no data read", n_dr, 0);
        check("R7 one data write", n_dw, 1);
        check("R2 address first on write", first_kind, 1);
        check("R1 address on write", areg, exp_addr(8'h7E, 5'h02, 3'h3, 12'h204));
    endtask

    task automatic t_bad_size();
        logic [2:0] bad [5] = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};
        stall = 0;
        foreach (bad[i]) begin
            dreg = 32'h0BAD_0BAD;
            do_req(8'h09, 5'h01, 3'h0, 12'h040, bad[i], i[0], 32'h1357_9BDF, 1'b0);
            check("R8 bad status", {31'd0, got_status}, 32'd1);
            check("R8 no bus traffic", n_aw + n_dr + n_dw + n_bad_addr, 0);
            check("R8 rdata zero", got_rdata, 32'd0);
            check("R8 data untouched", dreg, 32'h0BAD_0BAD);
        end
    endtask

    task automatic t_busy_ignore();
        stall = 3;
        dreg = 32'hA0A1_A2A3;
        do_req(8'h44, 5'h05, 3'h2, 12'h301, 3'd1, 1'b0, '0, 1'b1);
        check("R10 first result kept", got_rdata, 32'h0000_00A2);
        check("R10 single address write", n_aw, 1);
        check("R10 address not re-latched", areg, exp_addr(8'h44, 5'h05, 3'h2, 12'h301));
        check("R10 data untouched", dreg, 32'hA0A1_A2A3);
        @(negedge clk);
        check("R10 idle after ignore", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_stall_hold();
        stall = 5;
        dreg = 32'h0F0F_0F0F;
        do_req(8'hFF, 5'h1F, 3'h7, 12'hFFF, 3'd1, 1'b1, 32'h0000_0066, 1'b0);
        check("R11 stalled merge", dreg, 32'h660F_0F0F);
        check("R11 stalled address", areg, 32'h8FFF_FFFC);
        check("R2 stalled order", first_kind, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_addr_layout();
        t_read_byte();
        t_read_half();
        t_write_narrow();
        t_write_word();
        t_bad_size();
        t_busy_ignore();
        t_stall_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule